// File: doc/BRIEF.md
# NOR Flash Program and Erase Unit

This block holds a byte-wide storage array that behaves like NOR flash. A command sequencer issues one request at a time: a byte read, a single-byte program, or an erase of a region. Programming follows the NOR rule. A stored bit can only be cleared, so the written value is the AND of the old byte and the new data. A configuration bit switches the block to plain overwrite, which gives EEPROM-like behaviour. Erases fill a region with 0xFF, one byte per clock, and keep a busy output high until the fill is complete.

Modifying requests are gated by a write-enable input. A program refused for that reason raises a warning. An erase refused for that reason is dropped without comment. A capability mask states which of the two small erase sizes the configured part supports. Asking for a size outside that mask raises an error pulse, but the erase is still carried out.

The array size is the sector size times the sector count. The two fixed erase lengths are parameters: a small size (4 KiB on a full-size part) and a medium size (32 KiB on a full-size part). The defaults are scaled down so that the test array stays small. After reset the block sweeps the whole array to 0xFF before it accepts any request.

Top module: `nor_flash_pe`

## Requirements
- R1: After synchronous reset is released, `busy` stays high for exactly DEPTH clocks (DEPTH = SECTOR_BYTES*SECTOR_COUNT, 512 by default). Every byte then reads 0xFF.
- R2: A read (`req_op`=0) accepted at a clock edge sets `rd_valid` for one cycle after that edge. During that cycle `rd_data` holds the addressed byte. `rd_valid` is never high otherwise.
- R3: A program (`req_op`=1) with `part_flags[8]`=0 stores the bitwise AND of the old byte and `req_data`.
- R4: With `part_flags[8]`=1, a program stores `req_data` unchanged, so bits may return to 1.
- R5: When a program is performed and `req_data` has a 1 where the old byte has a 0, `warn_set` pulses for one cycle, after the write edge.
- R6: A program accepted while `wr_en`=0 leaves the array unchanged. It pulses `warn_wp` in the cycle after acceptance and does not raise `busy`.
- R7: Erase opcodes 2 (small, SMALL_ERASE_BYTES), 3 (medium, MID_ERASE_BYTES) and 4 (sector, SECTOR_BYTES) align `req_addr` down to a multiple of their length. They then set that whole region to 0xFF and leave all other bytes unchanged.
- R8: Erase opcode 5 sets the entire array to 0xFF starting at address 0, whatever the value of `req_addr`.
- R9: An erase accepted while `wr_en`=0 changes no byte, and `busy` stays low.
- R10: `err_size` pulses in the cycle after an erase request with opcode 2 while `part_flags[0]`=0, or with opcode 3 while `part_flags[1]`=0. This happens whether or not the erase is performed, and a performed erase completes normally.
- R11: A performed erase holds `busy` high for exactly as many cycles as bytes in its region. A request presented while `busy` is high is ignored.
- R12: A performed program holds `busy` high for exactly one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the 0xFF sweep |
| wr_en | input | 1 | Write enable for program and erase |
| part_flags | input | 9 | Bit 0: small erase supported; bit 1: medium erase supported; bit 8: direct overwrite |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_op | input | 3 | 0 read, 1 program, 2 small erase, 3 medium erase, 4 sector erase, 5 whole-array erase |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 8 | Program data |
| busy | output | 1 | Program or erase in progress; requests ignored |
| rd_valid | output | 1 | Read data valid this cycle |
| rd_data | output | 8 | Read data |
| err_size | output | 1 | Pulse: erase size not in capability mask |
| warn_wp | output | 1 | Pulse: program refused, write enable low |
| warn_set | output | 1 | Pulse: program tried to raise a cleared bit |

## Verification
The capability check and the write-enable gate act on the same erase request in the same cycle, and they must not mask each other. The bench issues a small-size erase with the capability bit clear and `wr_en` low. It expects `err_size` to pulse, `busy` to stay low, and a full read sweep to match the unchanged model. A second collision places a read request inside a running erase: the bench expects no `rd_valid`, and expects the busy window length and the filled region to be unaffected.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int FLAG_W        = 9;
    localparam int CAP_SMALL_BIT = 0;
    localparam int CAP_MID_BIT   = 1;
    localparam int OVERWRITE_BIT = 8;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_PROG     = 3'd1,
        OP_ER_SMALL = 3'd2,
        OP_ER_MID   = 3'd3,
        OP_ER_SECT  = 3'd4,
        OP_ER_ALL   = 3'd5
    } flash_op_e;

    typedef struct packed {
        logic [7:0] stored;
        logic       sets_bit;
    } merge_t;

    function automatic logic is_erase(input logic [2:0] op);
        return (op == OP_ER_SMALL) || (op == OP_ER_MID) ||
               (op == OP_ER_SECT)  || (op == OP_ER_ALL);
    endfunction

    function automatic logic size_unsupported(input logic [2:0] op,
                                              input logic [FLAG_W-1:0] flags);
        return ((op == OP_ER_SMALL) && !flags[CAP_SMALL_BIT]) ||
               ((op == OP_ER_MID)   && !flags[CAP_MID_BIT]);
    endfunction

endpackage

// File: rtl/flash_byte_ram.sv
module flash_byte_ram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/flash_fill_walker.sv
module flash_fill_walker #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              active,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            ptr    <= '0;
            stop_q <= TOP_ADDR;
        end else if (start) begin
            active <= 1'b1;
            ptr    <= first_addr;
            stop_q <= last_addr;
        end else if (active) begin
            if (ptr == stop_q) begin
                active <= 1'b0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_prog_merge.sv
module flash_prog_merge
    import flash_pkg::*;
(
    input  logic [7:0] old_byte,
    input  logic [7:0] new_byte,
    input  logic       overwrite,
    output merge_t     result
);
    always_comb begin
        result.sets_bit = |(~old_byte & new_byte);
        result.stored   = overwrite ? new_byte : (old_byte & new_byte);
    end
endmodule

// File: rtl/nor_flash_pe.sv
module nor_flash_pe
    import flash_pkg::*;
#(
    parameter int SECTOR_BYTES      = 64,
    parameter int SECTOR_COUNT      = 8,
    parameter int SMALL_ERASE_BYTES = 16,
    parameter int MID_ERASE_BYTES   = 128,
    localparam int DEPTH            = SECTOR_BYTES * SECTOR_COUNT,
    localparam int ADDR_W           = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [8:0]        part_flags,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              err_size,
    output logic              warn_wp,
    output logic              warn_set
);
    // request acceptance
    logic accept;
    logic take_read, take_prog, take_erase;

    // program pipeline
    logic              prog_phase;
    logic              prog_ovw;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    merge_t            merged;

    // erase region
    int unsigned       region_len;
    logic [ADDR_W-1:0] region_first;
    logic [ADDR_W-1:0] region_last;
    logic              fill_active;
    logic [ADDR_W-1:0] fill_ptr;

    // storage port
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;

    assign busy       = fill_active | prog_phase;
    assign accept     = req_valid & ~busy;
    assign take_read  = accept & (req_op == OP_READ);
    assign take_prog  = accept & (req_op == OP_PROG);
    assign take_erase = accept & is_erase(req_op);

    // region selection: length by opcode, start aligned down to the length
    always_comb begin
        unique case (req_op)
            OP_ER_SMALL: region_len = SMALL_ERASE_BYTES;
            OP_ER_MID:   region_len = MID_ERASE_BYTES;
            OP_ER_SECT:  region_len = SECTOR_BYTES;
            default:     region_len = DEPTH;
        endcase
        if (region_len >= DEPTH) begin
            region_first = '0;
            region_last  = ADDR_W'(DEPTH - 1);
        end else begin
            region_first = req_addr & ~ADDR_W'(region_len - 1);
            region_last  = region_first + ADDR_W'(region_len - 1);
        end
    end

    flash_fill_walker #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) i_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (take_erase & wr_en),
        .first_addr (region_first),
        .last_addr  (region_last),
        .active     (fill_active),
        .ptr        (fill_ptr)
    );

    flash_prog_merge i_merge (
        .old_byte  (ram_rdata),
        .new_byte  (prog_data),
        .overwrite (prog_ovw),
        .result    (merged)
    );

    always_comb begin
        if (fill_active) begin
            ram_addr  = fill_ptr;
            ram_we    = 1'b1;
            ram_wdata = 8'hFF;
        end else if (prog_phase) begin
            ram_addr  = prog_addr;
            ram_we    = 1'b1;
            ram_wdata = merged.stored;
        end else begin
            ram_addr  = req_addr;
            ram_we    = 1'b0;
            ram_wdata = 8'hFF;
        end
    end

    flash_byte_ram #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) i_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign rd_data = ram_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_phase <= 1'b0;
            prog_ovw   <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            rd_valid   <= 1'b0;
            err_size   <= 1'b0;
            warn_wp    <= 1'b0;
            warn_set   <= 1'b0;
        end else begin
            prog_phase <= take_prog & wr_en;
            rd_valid   <= take_read;
            err_size   <= take_erase & size_unsupported(req_op, part_flags);
            warn_wp    <= take_prog & ~wr_en;
            warn_set   <= prog_phase & merged.sets_bit;
            if (take_prog) begin
                prog_ovw  <= part_flags[OVERWRITE_BIT];
                prog_addr <= req_addr;
                prog_data <= req_data;
            end
        end
    end
endmodule

// File: rtl/flash_pe_checks.sv
module flash_pe_checks
    import flash_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [8:0] part_flags,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       busy,
    input logic       rd_valid,
    input logic       err_size,
    input logic       warn_wp
);
    logic acc;
    assign acc = req_valid & ~busy;

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == OP_READ) |=> rd_valid);

    assert_read_source_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc && req_op == OP_READ));

    assert_prog_window_R12: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == OP_PROG && wr_en) |=> busy ##1 !busy);

    assert_wp_refuse_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == OP_PROG && !wr_en) |=> (warn_wp && !busy));

    assert_erase_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (acc && is_erase(req_op) && !wr_en) |=> !busy);

    assert_erase_start_R11: assert property (@(posedge clk) disable iff (rst)
        (acc && is_erase(req_op) && wr_en) |=> busy);

    assert_size_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && ((req_op == OP_ER_SMALL && !part_flags[CAP_SMALL_BIT]) ||
                 (req_op == OP_ER_MID && !part_flags[CAP_MID_BIT]))) |=> err_size);
endmodule

bind nor_flash_pe flash_pe_checks i_checks (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .part_flags (part_flags),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .err_size   (err_size),
    .warn_wp    (warn_wp)
);

// File: tb/test_nor_flash_pe.sv
`timescale 1ns/1ps
module test_nor_flash_pe;
    localparam int DEPTH  = 512;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [8:0]        part_flags = 9'h003;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = 3'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = '0;
    logic              busy, rd_valid, err_size, warn_wp, warn_set;
    logic [7:0]        rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    nor_flash_pe i_nor_flash_pe (
        .clk(clk), .rst(rst), .wr_en(wr_en), .part_flags(part_flags),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_size(err_size), .warn_wp(warn_wp),
        .warn_set(warn_set)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int erase_len(input int op);
        case (op)
            2: return 16;
            3: return 128;
            4: return 64;
            default: return DEPTH;
        endcase
    endfunction

    // called at a falling edge, returns at a falling edge
    task automatic do_read(input int addr, input string tag);
        req_valid = 1'b1; req_op = 3'd0; req_addr = ADDR_W'(addr);
        @(posedge clk); #1;
        chk(rd_valid === 1'b1, "R2 rd_valid", int'(rd_valid), 1);
        chk(rd_data === model[addr], tag, int'(rd_data), int'(model[addr]));
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) do_read(a, tag);
    endtask

    task automatic do_prog(input int addr, input logic [7:0] data, input bit wen);
        logic [7:0] nv;
        bit         exp_set;
        exp_set = |(~model[addr] & data);
        nv = part_flags[8] ? data : (model[addr] & data);
        wr_en = wen; req_valid = 1'b1; req_op = 3'd1;
        req_addr = ADDR_W'(addr); req_data = data;
        @(posedge clk); #1;
        chk(warn_wp === !wen, "R6 warn_wp", int'(warn_wp), int'(!wen));
        chk(busy === wen, "R12 busy after accept", int'(busy), int'(wen));
        @(negedge clk); req_valid = 1'b0;
        if (wen) begin
            @(posedge clk); #1;
            chk(warn_set === exp_set, "R5 warn_set", int'(warn_set), int'(exp_set));
            chk(busy === 1'b0, "R12 busy released", int'(busy), 0);
            model[addr] = nv;
            @(negedge clk);
        end
    endtask

    task automatic do_erase(input int op, input int addr, input bit wen, input string tag);
        int  len, first, last, cnt;
        bit  exp_err;
        len = erase_len(op);
        exp_err = (op == 2 && !part_flags[0]) || (op == 3 && !part_flags[1]);
        wr_en = wen; req_valid = 1'b1; req_op = 3'(op); req_addr = ADDR_W'(addr);
        @(posedge clk); #1;
        chk(err_size === exp_err, "R10 err_size", int'(err_size), int'(exp_err));
        chk(busy === wen, wen ? "R11 busy start" : "R9 busy stays low", int'(busy), int'(wen));
        @(negedge clk); req_valid = 1'b0;
        if (wen) begin
            first = (len >= DEPTH) ? 0 : (addr & ~(len - 1));
            last  = ((first + len) > DEPTH ? DEPTH : first + len) - 1;
            // a read presented during the fill must be ignored
            req_valid = 1'b1; req_op = 3'd0; req_addr = '0;
            cnt = 1;
            for (int g = 0; g < 4 * DEPTH; g++) begin
                @(posedge clk); #1;
                if (g == 0) begin
                    chk(rd_valid === 1'b0, "R11 request ignored while busy", int'(rd_valid), 0);
                    req_valid = 1'b0;
                end
                if (busy) cnt++;
                else break;
            end
            chk(cnt == last - first + 1, {tag, " busy length R11"}, cnt, last - first + 1);
            for (int a = first; a <= last; a++) model[a] = 8'hFF;
            @(negedge clk);
        end
        sweep(tag);
    endtask

    task automatic random_mix(input int n);
        for (int k = 0; k < n; k++) begin
            part_flags[8] = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0)
                do_read($urandom_range(0, DEPTH - 1), "R3/R4 random read");
            else
                do_prog($urandom_range(0, DEPTH - 1), 8'($urandom),
                        $urandom_range(0, 3) != 0);
        end
        part_flags[8] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(busy === 1'b1, "R1 busy at reset release", int'(busy), 1);
        chk(rd_valid === 1'b0, "R2 rd_valid in reset state", int'(rd_valid), 0);
        cnt = 0;
        for (int g = 0; g < 4 * DEPTH; g++) begin
            @(posedge clk); #1;
            cnt++;
            if (!busy) break;
        end
        chk(cnt == DEPTH, "R1 reset sweep length", cnt, DEPTH);
        @(negedge clk);
        sweep("R1 array erased after reset");

        // directed program rules
        part_flags = 9'h003;
        do_prog(5, 8'hA5, 1'b1);
        do_read(5, "R3 AND with erased byte");
        do_prog(5, 8'h5A, 1'b1);
        do_read(5, "R3 AND clears bits, R5 raise attempt");
        part_flags[8] = 1'b1;
        do_prog(5, 8'h3C, 1'b1);
        do_read(5, "R4 direct overwrite");
        part_flags[8] = 1'b0;
        do_prog(6, 8'h00, 1'b0);
        do_read(6, "R6 refused program leaves byte");

        random_mix(300);
        sweep("R3/R4 after random programs");

        part_flags = 9'h003;
        do_erase(2, 9'h025, 1'b1, "R7 small erase");
        random_mix(100);
        part_flags = 9'h001;
        do_erase(3, 9'h1A3, 1'b1, "R10 unsupported medium still erased R7");
        random_mix(100);
        part_flags = 9'h003;
        do_erase(4, 9'h0C7, 1'b1, "R7 sector erase");
        random_mix(100);
        part_flags = 9'h000;
        do_erase(2, 9'h044, 1'b0, "R9 write-protected unsupported erase");
        do_erase(4, 9'h100, 1'b0, "R9 write-protected sector erase");
        random_mix(100);
        part_flags = 9'h003;
        do_erase(5, 9'h1F0, 1'b1, "R8 whole-array erase");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule